// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a single-channel SPI master seen by software as three 16-bit registers on a simple synchronous bus: a data word, a control word and a status word. Software writes a word to the data register. The block then shifts it out MSB first while it shifts the reply in from the slave. When the word is complete, software reads the reply back from the same register. Chip selects are driven elsewhere by general-purpose pins, so this block owns only the serial clock, the outgoing data line and the incoming data line.

The word width is 8 or 16 bits and is chosen by one control bit. Two control bits pick the idle level of the serial clock and which clock edge captures data, which covers all four usual SPI modes. The serial clock runs at the bus clock divided by 2·(N+1), where N is a 7-bit field. Two level interrupts tell software when the transmitter can take a word and when a received word is waiting. Software stops the engine by clearing the enable bit when a transfer ends or times out.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the control and status registers read 0, and the serial clock, the outgoing data line and both interrupts are low.
- R2: The data register is at byte offset 0, control at offset 2 and status at offset 4. The control register reads back the value last written. Its fields are enable in bit 0, 16-bit word in bit 2, receive interrupt enable in bit 5, transmit interrupt enable in bit 6, clock idle high in bit 7, capture on the second edge in bit 8, and the divider N in bits 15:9.
- R3: A write to the data register starts one word only while enable is 1 and status bit 0 (busy) is 0. A data write while disabled or while busy starts nothing and does not change the word being sent.
- R4: Busy stays set for exactly 2·W·(N+1) bus clock cycles, where W is 8 or 16. Each serial clock half period lasts N+1 cycles.
- R5: When idle, the serial clock sits at the level of control bit 7. With bit 8 clear, data is captured on the first edge of each bit and changed on the second edge. With bit 8 set, data is changed on the first edge and captured on the second. Mode 0 clears both bits, mode 1 sets only bit 8, mode 2 sets only bit 7 and mode 3 sets both.
- R6: Words go out MSB first, so in 16-bit mode the high byte is on the wire first. The first bit received lands in the highest bit of the word (bit 15, or bit 7 in 8-bit mode). In 8-bit mode the received word has bits 15:8 at zero.
- R7: Status bit 1 (receive full) is set when a word completes. A read of the data register clears it.
- R8: A word that completes while receive full is still set replaces the held word and leaves the flag set.
- R9: Clearing enable during a word stops it. Busy reads 0 and the serial clock sits at its idle level within one cycle after the control write.
- R10: The receive interrupt is high exactly while receive full and bit 5 are both set. The transmit interrupt is high exactly while enable is set, busy is clear and bit 6 is set.
- R11: A change to the divider or the mode bits while a word is shifting takes effect only from the next word. The current word keeps its timing and edges.
- R12: An 8-bit write to the data register (byte access) sends the low byte with the upper byte as zero. An 8-bit read of the data register returns the received low byte with bits 15:8 at zero.
- R13: The outgoing data line changes only on change edges and holds the last bit of a word while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_byte | input | 1 | 1 for an 8-bit access to the data register |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, same cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| irq_rx | output | 1 | Received word waiting |
| irq_tx | output | 1 | Transmitter ready for a word |

## Verification
A wrong bit counter or wrong edge selection shows up at the end of the first word. Busy falls at the wrong cycle, the word a bus-side slave model collects differs, or the received word read back is shifted by a bit. A bad divider reload changes the busy length of every word at once. A configuration latch that follows live writes only shows when the divider changes in the middle of a word, so the bench does this on purpose. A stuck receive flag or interrupt shows on the next status read after a data read.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
   localparam int WORD_W = 16;
   localparam int DIV_W  = 7;

   // Control word layout, bit 15 down to bit 0
   typedef struct packed {
      logic [DIV_W-1:0] div;      // half period = div+1 cycles
      logic             late;     // capture on second edge of a bit
      logic             idle_hi;  // serial clock idle level
      logic             wr_ie;    // transmit-ready interrupt enable
      logic             rd_ie;    // receive interrupt enable
      logic [1:0]       spare_b;
      logic             wide;     // 16-bit words
      logic             spare_a;
      logic             en;
   } ctl_t;

   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_CTL  = 3'd2;
   localparam logic [2:0] OFS_STAT = 3'd4;
endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
   import spi_rm_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_byte,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              busy,
   input  logic              done,
   input  logic [WORD_W-1:0] rx_word,
   output ctl_t              ctl_q,
   output logic              start,
   output logic [WORD_W-1:0] tx_word,
   output logic              rx_full
);
   logic hit_data, hit_ctl, hit_stat, wr_ctl, rd_data;

   assign hit_data = bus_sel && (bus_addr == ADDR_W'(OFS_DATA));
   assign hit_ctl  = bus_sel && (bus_addr == ADDR_W'(OFS_CTL));
   assign hit_stat = bus_sel && (bus_addr == ADDR_W'(OFS_STAT));
   assign wr_ctl   = hit_ctl && bus_wr;
   assign rd_data  = hit_data && !bus_wr;
   assign start    = hit_data && bus_wr && ctl_q.en && !busy;
   assign tx_word  = bus_byte ? {8'h00, bus_wdata[7:0]} : bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         rx_full <= 1'b0;
      end else begin
         if (wr_ctl) ctl_q <= ctl_t'(bus_wdata);
         if (done) rx_full <= 1'b1;
         else if (rd_data) rx_full <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_data)
         bus_rdata = bus_byte ? {8'h00, rx_word[7:0]} : rx_word;
      else if (hit_ctl)
         bus_rdata = ctl_q;
      else if (hit_stat)
         bus_rdata = {{(WORD_W-2){1'b0}}, rx_full, busy};
   end

   assert_rxfull_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_full);
   assert_rxfull_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !done) |=> !rx_full);
   assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_data) |=> rx_full);
   assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctl |=> $stable(ctl_q));
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter
   import spi_rm_pkg::*;
#(
   parameter bit SYNC_MISO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wide,
   input  logic              idle_hi,
   input  logic              late,
   input  logic [DIV_W-1:0]  div,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi
);
   localparam int EDGES  = 2 * WORD_W;
   localparam int EDGE_W = $clog2(EDGES);
   localparam int HALF_W = WORD_W / 2;

   if (WORD_W != 16) begin : g_bad_width
      $error("shifter assumes 16-bit words");
   end

   logic miso_s;
   if (SYNC_MISO) begin : g_miso_flop
      logic miso_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) miso_q <= 1'b0;
         else        miso_q <= miso;
      assign miso_s = miso_q;
   end else begin : g_miso_direct
      assign miso_s = miso;
   end

   logic [DIV_W-1:0]  cnt, div_l;
   logic [EDGE_W-1:0] edge_idx;
   logic              phase, cpol_l, cpha_l, wide_l, mosi_q;
   logic [WORD_W-1:0] txsh, rxsh, rx_nxt, tx_aln;
   logic              tick, samp, drive, last;

   assign tick   = busy && (cnt == div_l);
   assign samp   = (~edge_idx[0]) ^ cpha_l;
   assign drive  = ~samp;
   assign last   = edge_idx == (wide_l ? EDGE_W'(EDGES - 1) : EDGE_W'(WORD_W - 1));
   assign rx_nxt = samp ? {rxsh[WORD_W-2:0], miso_s} : rxsh;
   assign tx_aln = wide ? tx_word : {tx_word[HALF_W-1:0], {HALF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; phase <= 1'b0;
         cnt <= '0; div_l <= '0; edge_idx <= '0;
         cpol_l <= 1'b0; cpha_l <= 1'b0; wide_l <= 1'b0;
         txsh <= '0; rxsh <= '0; rx_word <= '0; mosi_q <= 1'b0;
      end else if (!en) begin
         busy <= 1'b0; done <= 1'b0; phase <= 1'b0;
         cnt <= '0; edge_idx <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1; phase <= 1'b0; cnt <= '0; edge_idx <= '0;
            div_l <= div; cpol_l <= idle_hi; cpha_l <= late; wide_l <= wide;
            rxsh <= '0;
            if (!late) begin
               mosi_q <= tx_aln[WORD_W-1];
               txsh   <= {tx_aln[WORD_W-2:0], 1'b0};
            end else begin
               txsh   <= tx_aln;
            end
         end else if (busy) begin
            if (tick) begin
               cnt      <= '0;
               phase    <= ~phase;
               edge_idx <= edge_idx + EDGE_W'(1);
               rxsh     <= rx_nxt;
               if (drive && !last) begin
                  mosi_q <= txsh[WORD_W-1];
                  txsh   <= {txsh[WORD_W-2:0], 1'b0};
               end
               if (last) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  rx_word <= wide_l ? rx_nxt : {{HALF_W{1'b0}}, rx_nxt[HALF_W-1:0]};
               end
            end else begin
               cnt <= cnt + DIV_W'(1);
            end
         end
      end
   end

   assign sclk = busy ? (cpol_l ^ phase) : idle_hi;
   assign mosi = mosi_q;

   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);
   assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && en) |=> busy);
   assert_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (!busy || ($stable(div_l) && $stable(cpol_l)
                                       && $stable(cpha_l) && $stable(wide_l))));
   assert_mosi_capture_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && samp && !start) |=> $stable(mosi_q));
   assert_mosi_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(mosi_q));
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
   import spi_rm_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter bit SYNC_MISO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_byte,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              irq_rx,
   output logic              irq_tx
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach offset 4");
   end
   if ($bits(ctl_t) != WORD_W) begin : g_bad_ctl
      $error("control layout must fill one word");
   end

   ctl_t              ctl_q;
   logic              start, busy, done, rx_full;
   logic [WORD_W-1:0] tx_word, rx_word;

   spi_rm_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .busy(busy), .done(done), .rx_word(rx_word),
      .ctl_q(ctl_q), .start(start), .tx_word(tx_word), .rx_full(rx_full)
   );

   spi_rm_shifter #(.SYNC_MISO(SYNC_MISO)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .wide(ctl_q.wide),
      .idle_hi(ctl_q.idle_hi), .late(ctl_q.late), .div(ctl_q.div),
      .start(start), .tx_word(tx_word), .miso(spi_miso), .busy(busy),
      .done(done), .rx_word(rx_word), .sclk(spi_sclk), .mosi(spi_mosi)
   );

   assign irq_rx = rx_full && ctl_q.rd_ie;
   assign irq_tx = ctl_q.en && !busy && ctl_q.wr_ie;

   assert_irq_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (irq_rx == ctl_q.rd_ie));
   assert_irq_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ctl_q.en) |=> !irq_tx);
endmodule

// File: tb/spi_regmaster_bench.sv
`timescale 1ns/1ps
module spi_regmaster_bench;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, bus_sel, bus_wr, bus_byte, spi_miso;
   logic [2:0]  bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic        spi_sclk, spi_mosi, irq_rx, irq_tx;

   spi_regmaster u_spi_regmaster (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .irq_rx(irq_rx), .irq_tx(irq_tx)
   );

   int checks = 0, fails = 0;
   bit finished = 0;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // slave model
   logic        s_cpol = 0, s_cpha = 0, sclk_prev = 0;
   logic [15:0] s_tx = 0, s_rx = 0;
   always @(negedge clk) begin
      if (spi_sclk !== sclk_prev) begin
         if ((sclk_prev == s_cpol) ^ s_cpha)
            s_rx = {s_rx[14:0], spi_mosi};
         else begin
            spi_miso = s_tx[15];
            s_tx = {s_tx[14:0], 1'b0};
         end
      end
      sclk_prev = spi_sclk;
   end

   task automatic arm(bit cp, bit ch, bit wd, logic [15:0] sw);
      s_cpol = cp; s_cpha = ch; s_rx = 0;
      s_tx = wd ? sw : {sw[7:0], 8'h00};
      if (!ch) begin
         spi_miso = s_tx[15];
         s_tx = {s_tx[14:0], 1'b0};
      end
   endtask

   task automatic op(bit wr, bit byt, logic [2:0] a, logic [15:0] d, output logic [15:0] q);
      @(negedge clk);
      bus_sel = 1; bus_wr = wr; bus_byte = byt; bus_addr = a; bus_wdata = d;
      #1 q = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 0; bus_wr = 0; bus_byte = 0;
   endtask

   task automatic wait_idle(inout int n);
      logic [15:0] q;
      for (int i = 0; i < 4000; i++) begin
         op(0, 0, 3'd4, 16'h0, q);
         if (!q[0]) break;
         n++;
      end
   endtask

   function automatic logic [15:0] ctlword(int mode, bit wide, int dv, bit en);
      return 16'(en) | (16'(wide) << 2) | 16'h0060 | (16'(mode >> 1) << 7)
             | (16'(mode & 1) << 8) | (16'(dv) << 9);
   endfunction

   task automatic xfer(int mode, bit wide, int dv, logic [15:0] w, logic [15:0] sw, bit rd);
      logic [15:0] q;
      int n = 0;
      int bits = wide ? 16 : 8;
      op(1, 0, 3'd2, ctlword(mode, wide, dv, 1), q);
      chk("R5", "idle sclk", int'(spi_sclk), mode >> 1);
      chk("R10", "irq_tx ready", int'(irq_tx), 1);
      op(0, 0, 3'd4, 16'h0, q);
      chk("R3", "not busy before start", int'(q[0]), 0);
      arm(1'(mode >> 1), 1'(mode & 1), wide, sw);
      op(1, 0, 3'd0, w, q);
      chk("R10", "irq_tx while busy", int'(irq_tx), 0);
      wait_idle(n);
      chk("R4", "busy cycles", n, 2 * bits * (dv + 1));
      op(0, 0, 3'd4, 16'h0, q);
      chk("R7", "status after word", int'(q), 2);
      chk("R10", "irq_rx set", int'(irq_rx), 1);
      chk("R6", "slave got word", int'(wide ? s_rx : {8'h00, s_rx[7:0]}),
          int'(wide ? w : {8'h00, w[7:0]}));
      chk("R13", "mosi holds last bit", int'(spi_mosi), int'(w[0]));
      if (rd) begin
         op(0, 0, 3'd0, 16'h0, q);
         chk("R6", "received word", int'(q), int'(wide ? sw : {8'h00, sw[7:0]}));
         op(0, 0, 3'd4, 16'h0, q);
         chk("R7", "rx full cleared", int'(q), 0);
         chk("R10", "irq_rx cleared", int'(irq_rx), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R4 watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] q;
      int n;
      rst_n = 0; bus_sel = 0; bus_wr = 0; bus_byte = 0; bus_addr = 0;
      bus_wdata = 0; spi_miso = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      op(0, 0, 3'd2, 16'h0, q); chk("R1", "control", int'(q), 0);
      op(0, 0, 3'd4, 16'h0, q); chk("R1", "status", int'(q), 0);
      chk("R1", "sclk", int'(spi_sclk), 0);
      chk("R1", "mosi", int'(spi_mosi), 0);
      chk("R1", "irqs", int'({irq_rx, irq_tx}), 0);
      // R2 control readback
      op(1, 0, 3'd2, 16'hA5E4, q);
      op(0, 0, 3'd2, 16'h0, q); chk("R2", "control readback", int'(q), 16'hA5E4);
      // R3 disabled write
      op(1, 0, 3'd0, 16'h1234, q);
      op(0, 0, 3'd4, 16'h0, q); chk("R3", "no start when disabled", int'(q), 0);
      // sweep: modes, widths, dividers
      for (int m = 0; m < 4; m++)
         for (int wd = 0; wd < 2; wd++)
            for (int dsel = 0; dsel < 2; dsel++) begin
               logic [15:0] w, sw;
               w  = 16'hA53C ^ 16'(m * 16'h1357 + wd * 16'h0F0F + dsel * 16'h8421);
               sw = {w[6:0], w[15:7]} ^ 16'h5AC3;
               xfer(m, 1'(wd), dsel ? 3 : 1, w, sw, 1);
            end
      // R8 overrun
      xfer(0, 1, 1, 16'h1111, 16'hBEEF, 0);
      xfer(3, 1, 1, 16'h2222, 16'hCAFE, 0);
      op(0, 0, 3'd0, 16'h0, q); chk("R8", "newest word kept", int'(q), 16'hCAFE);
      // R3 write while busy ignored
      op(1, 0, 3'd2, ctlword(1, 1, 2, 1), q);
      op(0, 0, 3'd4, 16'h0, q);
      arm(0, 1, 1, 16'h0F0F);
      op(1, 0, 3'd0, 16'hC3A5, q);
      n = 0;
      for (int i = 0; i < 4; i++) begin op(0, 0, 3'd4, 16'h0, q); n += int'(q[0]); end
      op(1, 0, 3'd0, 16'h7E81, q); n++;
      wait_idle(n);
      chk("R3", "busy cycles one word", n, 96);
      chk("R3", "slave got first word", int'(s_rx), 16'hC3A5);
      op(0, 0, 3'd4, 16'h0, q); chk("R3", "no restart", int'(q[0]), 0);
      op(0, 0, 3'd0, 16'h0, q); chk("R3", "reply", int'(q), 16'h0F0F);
      // R11 divider and edge change mid-word
      op(1, 0, 3'd2, ctlword(0, 1, 1, 1), q);
      op(0, 0, 3'd4, 16'h0, q);
      arm(0, 0, 1, 16'h96E1);
      op(1, 0, 3'd0, 16'h4D2B, q);
      n = 0;
      for (int i = 0; i < 3; i++) begin op(0, 0, 3'd4, 16'h0, q); n += int'(q[0]); end
      op(1, 0, 3'd2, ctlword(1, 1, 5, 1), q); n++;
      wait_idle(n);
      chk("R11", "busy cycles old divider", n, 64);
      chk("R11", "slave word old edges", int'(s_rx), 16'h4D2B);
      op(0, 0, 3'd0, 16'h0, q); chk("R11", "reply old edges", int'(q), 16'h96E1);
      // R9 abort
      op(1, 0, 3'd2, ctlword(0, 1, 7, 1), q);
      op(0, 0, 3'd4, 16'h0, q);
      arm(0, 0, 1, 16'h0);
      op(1, 0, 3'd0, 16'hFFFF, q);
      repeat (20) op(0, 0, 3'd4, 16'h0, q);
      chk("R9", "busy mid-word", int'(q[0]), 1);
      op(1, 0, 3'd2, 16'h0080, q);
      op(0, 0, 3'd4, 16'h0, q);
      op(0, 0, 3'd4, 16'h0, q); chk("R9", "busy after abort", int'(q[0]), 0);
      chk("R9", "sclk idle after abort", int'(spi_sclk), 1);
      // R12 byte access
      op(1, 0, 3'd2, ctlword(0, 1, 1, 1), q);
      op(0, 0, 3'd4, 16'h0, q);
      arm(0, 0, 1, 16'h1234);
      op(1, 1, 3'd0, 16'h77A5, q);
      n = 0; wait_idle(n);
      chk("R12", "byte write on wire", int'(s_rx), 16'h00A5);
      op(0, 1, 3'd0, 16'h0, q); chk("R12", "byte read", int'(q), 16'h0034);
      op(0, 0, 3'd4, 16'h0, q); chk("R7", "byte read clears", int'(q), 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule